// File: doc/BRIEF.md
# RF Band and Antenna Switch Decoder

This block converts the tuned receive and transmit frequencies of one RF front-end side into the control word for that side's filter banks, antenna switches and transmit amplifier enables. Both frequencies arrive as unsigned integers in 100 kHz steps. The block sorts each frequency into a half-open range: a range from A to B holds f when A <= f < B. It then maps the receive range to a three-stage receive filter selection and a receive path switch, and maps the transmit range to a transmit low-pass selection and an enable pair. The switch codes are irregular and do not rise with frequency, so they come from explicit per-range tables rather than arithmetic.

The shared transmit/receive antenna switch is driven by the receive side when the TRX port receives. When the RX2 port receives in full duplex, it takes the transmit decode. Every output that would be "don't care" is driven to 0. All outputs are registered. They take new values only on the clock edge that samples the update strobe high, so software or a tuning sequencer can change the frequency inputs at will and commit them in a single cycle. The control pins are plain levels with no handshake, because there is no data stream.

Top module: `rf_path_select`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, every output is 0. This includes tx_en = 00, which means no transmit.
- R2: Outputs change only on the rising clock edge at which upd is 1. In every other cycle they hold their values, whatever the other inputs do.
- R3: The receive ranges are split at 4500, 7000, 12000, 18000, 23500 and 26000 (100 kHz units). Each edge belongs to the upper range. Below 26000, rx_band takes these values for the ranges from lowest to highest: 101, 011, 001, 000, 010, 100.
- R4: rx_band_lo is 01, 11 and 10 for the three ranges below 12000, and 00 otherwise. rx_band_hi is 01, 11 and 10 for the ranges 12000–18000, 18000–23500 and 23500–26000, and 00 otherwise.
- R5: For rx_freq >= 26000, rx_band, rx_band_lo and rx_band_hi are all 0.
- R6: rx_sw depends on the port and the range. With rx_port_rx2 = 0 (TRX port), rx_sw is 10 below 26000 and 01 at or above it. With rx_port_rx2 = 1 (RX2 port), rx_sw is 01 below 26000 and 10 at or above it.
- R7: With rx_port_rx2 = 0, trx_sw is 01. With rx_port_rx2 = 1 and full_duplex = 1, trx_sw is 10 for tx_freq < 29400 and 11 for tx_freq >= 29400. With rx_port_rx2 = 1 and full_duplex = 0, trx_sw is 00.
- R8: The transmit ranges are split at 1177, 1782, 2843, 4537, 7238, 11549, 18426 and 29400. Each edge belongs to the upper range. tx_band is 111 in the lowest range and counts down by one per range to 000 in the range 18426–29400. For tx_freq >= 29400, tx_band is 000.
- R9: With tx_active = 1, tx_en is 01 for tx_freq < 29400 and 10 for tx_freq >= 29400.
- R10: With tx_active = 0, tx_en is 00 at any tx_freq. The transmit band selection is decoded as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd | input | 1 | Update strobe: commit a new control word on this edge |
| rx_freq | input | FREQ_W | Receive frequency, 100 kHz units |
| tx_freq | input | FREQ_W | Transmit frequency, 100 kHz units |
| rx_port_rx2 | input | 1 | 0 = receive on TRX port, 1 = receive on RX2 port |
| tx_active | input | 1 | Transmitter in use |
| full_duplex | input | 1 | Transmit and receive run together |
| trx_sw | output | 2 | Shared transmit/receive antenna switch |
| rx_sw | output | 2 | Receive path switch (filter bank or bypass) |
| rx_band | output | 3 | First-stage receive filter select |
| rx_band_lo | output | 2 | Second-stage select for the low receive ranges |
| rx_band_hi | output | 2 | Third-stage select for the middle receive ranges |
| tx_band | output | 3 | Transmit low-pass filter select |
| tx_en | output | 2 | Transmit enable pair |

## Verification
The assertions assume that the inputs are stable around the clock edge and that tx_freq and rx_freq are plain unsigned values, so that any 16-bit value is legal. They also assume that upd may stay high for several cycles. The bench drives every input on the falling edge, then pulses upd for exactly one cycle and samples after the following falling edge. It walks each range edge and the value one step below it, and it also uses 0 and the all-ones frequency. In the hold test it changes the frequencies, the port and the flags while upd stays low, so the stability property sees real input activity.

// File: rtl/rfsel_pkg.sv
`timescale 1ns/1ps
package rfsel_pkg;
  localparam int EDGE_W   = 32;
  localparam int RX_EDGES = 6;
  localparam int TX_EDGES = 8;

  // Range edges in 100 kHz units, lowest edge in the least significant slot.
  localparam logic [RX_EDGES*EDGE_W-1:0] RX_EDGE_LIST =
    {32'd26000, 32'd23500, 32'd18000, 32'd12000, 32'd7000, 32'd4500};
  localparam logic [TX_EDGES*EDGE_W-1:0] TX_EDGE_LIST =
    {32'd29400, 32'd18426, 32'd11549, 32'd7238, 32'd4537, 32'd2843, 32'd1782, 32'd1177};

  typedef struct packed {
    logic [1:0] trx_sw;
    logic [1:0] rx_sw;
    logic [2:0] rx_band;
    logic [1:0] rx_band_lo;
    logic [1:0] rx_band_hi;
    logic [2:0] tx_band;
    logic [1:0] tx_en;
  } sw_word_t;
endpackage

// File: rtl/rfsel_range_idx.sv
`timescale 1ns/1ps
module rfsel_range_idx #(
  parameter int FREQ_W = 16,
  parameter int N      = 6,
  parameter logic [N*32-1:0] EDGES = '0,
  localparam int IDX_W = $clog2(N + 1)
) (
  input  logic [FREQ_W-1:0] freq,
  output logic [IDX_W-1:0]  idx
);
  logic [N-1:0] at_or_above;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign at_or_above[i] = 32'(freq) >= EDGES[i*32 +: 32];
  end

  // Edges rise monotonically, so the count of passed edges is the range index.
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) idx = idx + IDX_W'(at_or_above[i]);
  end
endmodule

// File: rtl/rfsel_rx_map.sv
`timescale 1ns/1ps
module rfsel_rx_map #(
  parameter int N = 6,
  localparam int IDX_W = $clog2(N + 1)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             rx2_port,
  output logic [1:0]       rx_sw,
  output logic [2:0]       band,
  output logic [1:0]       band_lo,
  output logic [1:0]       band_hi
);
  logic bypass;
  assign bypass = idx >= IDX_W'(N);

  always_comb begin
    band    = 3'b000;
    band_lo = 2'b00;
    band_hi = 2'b00;
    case (idx)
      IDX_W'(0): begin band = 3'b101; band_lo = 2'b01; end
      IDX_W'(1): begin band = 3'b011; band_lo = 2'b11; end
      IDX_W'(2): begin band = 3'b001; band_lo = 2'b10; end
      IDX_W'(3): begin band = 3'b000; band_hi = 2'b01; end
      IDX_W'(4): begin band = 3'b010; band_hi = 2'b11; end
      IDX_W'(5): begin band = 3'b100; band_hi = 2'b10; end
      default:   ;
    endcase
    rx_sw = (bypass ^ rx2_port) ? 2'b01 : 2'b10;
  end
endmodule

// File: rtl/rfsel_tx_map.sv
`timescale 1ns/1ps
module rfsel_tx_map #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N + 1)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             active,
  output logic [2:0]       band,
  output logic [1:0]       sw,
  output logic [1:0]       en
);
  logic high;
  assign high = idx >= IDX_W'(N);

  always_comb begin
    band = high ? 3'b000 : 3'(IDX_W'(N - 1) - idx);
    sw   = high ? 2'b11 : 2'b10;
    if (!active)   en = 2'b00;
    else if (high) en = 2'b10;
    else           en = 2'b01;
  end
endmodule

// File: rtl/rf_path_select.sv
`timescale 1ns/1ps
module rf_path_select
  import rfsel_pkg::*;
#(
  parameter int FREQ_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [FREQ_W-1:0] rx_freq,
  input  logic [FREQ_W-1:0] tx_freq,
  input  logic              rx_port_rx2,
  input  logic              tx_active,
  input  logic              full_duplex,
  output logic [1:0]        trx_sw,
  output logic [1:0]        rx_sw,
  output logic [2:0]        rx_band,
  output logic [1:0]        rx_band_lo,
  output logic [1:0]        rx_band_hi,
  output logic [2:0]        tx_band,
  output logic [1:0]        tx_en
);
  localparam int RX_IDX_W = $clog2(RX_EDGES + 1);
  localparam int TX_IDX_W = $clog2(TX_EDGES + 1);

  logic [RX_IDX_W-1:0] rx_idx;
  logic [TX_IDX_W-1:0] tx_idx;
  logic [1:0]          tx_sw;
  sw_word_t            nxt, cur;

  rfsel_range_idx #(.FREQ_W(FREQ_W), .N(RX_EDGES), .EDGES(RX_EDGE_LIST))
    u_rx_idx (.freq(rx_freq), .idx(rx_idx));
  rfsel_range_idx #(.FREQ_W(FREQ_W), .N(TX_EDGES), .EDGES(TX_EDGE_LIST))
    u_tx_idx (.freq(tx_freq), .idx(tx_idx));

  rfsel_rx_map #(.N(RX_EDGES)) u_rx_map (
    .idx(rx_idx), .rx2_port(rx_port_rx2), .rx_sw(nxt.rx_sw),
    .band(nxt.rx_band), .band_lo(nxt.rx_band_lo), .band_hi(nxt.rx_band_hi));

  rfsel_tx_map #(.N(TX_EDGES)) u_tx_map (
    .idx(tx_idx), .active(tx_active), .band(nxt.tx_band), .sw(tx_sw), .en(nxt.tx_en));

  // Shared switch: receive side owns it on TRX; transmit side in RX2 full duplex.
  always_comb begin
    if (!rx_port_rx2)     nxt.trx_sw = 2'b01;
    else if (full_duplex) nxt.trx_sw = tx_sw;
    else                  nxt.trx_sw = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cur <= '0;
    else if (upd) cur <= nxt;
  end

  assign trx_sw     = cur.trx_sw;
  assign rx_sw      = cur.rx_sw;
  assign rx_band    = cur.rx_band;
  assign rx_band_lo = cur.rx_band_lo;
  assign rx_band_hi = cur.rx_band_hi;
  assign tx_band    = cur.tx_band;
  assign tx_en      = cur.tx_en;
endmodule

// File: rtl/rf_path_select_chk.sv
`timescale 1ns/1ps
module rf_path_select_chk #(
  parameter int FREQ_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd,
  input logic [FREQ_W-1:0] rx_freq,
  input logic [FREQ_W-1:0] tx_freq,
  input logic              rx_port_rx2,
  input logic              tx_active,
  input logic              full_duplex,
  input logic [1:0]        trx_sw,
  input logic [1:0]        rx_sw,
  input logic [2:0]        rx_band,
  input logic [1:0]        rx_band_lo,
  input logic [1:0]        rx_band_hi,
  input logic [2:0]        tx_band,
  input logic [1:0]        tx_en
);
  logic [15:0] word;
  assign word = {trx_sw, rx_sw, rx_band, rx_band_lo, rx_band_hi, tx_band, tx_en};

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> word == '0);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(word));

  a_r4_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
    rx_band_lo == 2'b00 || rx_band_hi == 2'b00);

  a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    upd && 32'(rx_freq) >= 32'd26000 |=>
      rx_band == 3'b000 && rx_band_lo == 2'b00 && rx_band_hi == 2'b00);

  a_r7_trx_port: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !rx_port_rx2 |=> trx_sw == 2'b01);

  a_r9_tx_high: assert property (@(posedge clk) disable iff (!rst_n)
    upd && tx_active && 32'(tx_freq) >= 32'd29400 |=> tx_en == 2'b10 && tx_band == 3'b000);

  a_r10_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !tx_active |=> tx_en == 2'b00);
endmodule

bind rf_path_select rf_path_select_chk #(.FREQ_W(FREQ_W)) u_chk (.*);

// File: tb/test_rf_path_select.sv
`timescale 1ns/1ps
module test_rf_path_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0;
  logic [15:0] rx_freq = '0, tx_freq = '0;
  logic        rx_port_rx2 = 1'b0, tx_active = 1'b0, full_duplex = 1'b0;
  logic [1:0]  trx_sw, rx_sw, rx_band_lo, rx_band_hi, tx_en;
  logic [2:0]  rx_band, tx_band;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rf_path_select #(.FREQ_W(16)) i_rf_path_select (.*);

  function automatic logic [15:0] expect_word(int rf, int tf, bit rx2, bit ta, bit fd);
    logic [1:0] t_sw, r_sw, lo, hi, en, tsw_tx;
    logic [2:0] rb, tb;
    lo = 2'b00; hi = 2'b00;
    if      (rf < 4500)  begin rb = 3'b101; lo = 2'b01; end
    else if (rf < 7000)  begin rb = 3'b011; lo = 2'b11; end
    else if (rf < 12000) begin rb = 3'b001; lo = 2'b10; end
    else if (rf < 18000) begin rb = 3'b000; hi = 2'b01; end
    else if (rf < 23500) begin rb = 3'b010; hi = 2'b11; end
    else if (rf < 26000) begin rb = 3'b100; hi = 2'b10; end
    else                       rb = 3'b000;
    if (rf < 26000) r_sw = rx2 ? 2'b01 : 2'b10;
    else            r_sw = rx2 ? 2'b10 : 2'b01;
    if      (tf < 1177)  tb = 3'd7;
    else if (tf < 1782)  tb = 3'd6;
    else if (tf < 2843)  tb = 3'd5;
    else if (tf < 4537)  tb = 3'd4;
    else if (tf < 7238)  tb = 3'd3;
    else if (tf < 11549) tb = 3'd2;
    else if (tf < 18426) tb = 3'd1;
    else                 tb = 3'd0;
    tsw_tx = (tf < 29400) ? 2'b10 : 2'b11;
    en = !ta ? 2'b00 : ((tf < 29400) ? 2'b01 : 2'b10);
    t_sw = !rx2 ? 2'b01 : (fd ? tsw_tx : 2'b00);
    return {t_sw, r_sw, rb, lo, hi, tb, en};
  endfunction

  function automatic logic [15:0] outs();
    return {trx_sw, rx_sw, rx_band, rx_band_lo, rx_band_hi, tx_band, tx_en};
  endfunction

  task automatic check(string req, logic [15:0] exp);
    checks++;
    if (outs() !== exp) begin
      failures++;
      $display("FAIL %s rf=%0d tf=%0d actual=%h expected=%h", req, rx_freq, tx_freq, outs(), exp);
    end
  endtask

  task automatic apply(int rf, int tf, bit rx2, bit ta, bit fd);
    @(negedge clk);
    rx_freq = 16'(rf); tx_freq = 16'(tf);
    rx_port_rx2 = rx2; tx_active = ta; full_duplex = fd; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 16'h0000);
  endtask

  task automatic t_rx_sweep(bit rx2);
    int pts[14] = '{0, 4499, 4500, 6999, 7000, 11999, 12000,
                    17999, 18000, 23499, 23500, 25999, 26000, 65535};
    foreach (pts[i]) begin
      apply(pts[i], 1000, rx2, 1'b0, 1'b0);
      check(pts[i] >= 26000 ? "R5" : (pts[i] < 12000 ? "R3" : "R4"),
            expect_word(pts[i], 1000, rx2, 1'b0, 1'b0));
    end
    apply(25999, 1000, rx2, 1'b0, 1'b0);
    check("R6", expect_word(25999, 1000, rx2, 1'b0, 1'b0));
  endtask

  task automatic t_tx_sweep();
    int pts[18] = '{0, 1176, 1177, 1781, 1782, 2842, 2843, 4536, 4537,
                    7237, 7238, 11548, 11549, 18425, 18426, 29399, 29400, 65535};
    foreach (pts[i]) begin
      apply(5000, pts[i], 1'b0, 1'b1, 1'b0);
      check(pts[i] >= 29400 ? "R9" : "R8", expect_word(5000, pts[i], 1'b0, 1'b1, 1'b0));
    end
  endtask

  task automatic t_tx_off();
    apply(5000, 500, 1'b0, 1'b0, 1'b0);
    check("R10", expect_word(5000, 500, 1'b0, 1'b0, 1'b0));
    apply(5000, 40000, 1'b1, 1'b0, 1'b1);
    check("R10", expect_word(5000, 40000, 1'b1, 1'b0, 1'b1));
  endtask

  task automatic t_duplex();
    apply(30000, 29399, 1'b1, 1'b1, 1'b1);
    check("R7", expect_word(30000, 29399, 1'b1, 1'b1, 1'b1));
    apply(30000, 29400, 1'b1, 1'b1, 1'b1);
    check("R7", expect_word(30000, 29400, 1'b1, 1'b1, 1'b1));
    apply(8000, 29400, 1'b1, 1'b1, 1'b0);
    check("R7", expect_word(8000, 29400, 1'b1, 1'b1, 1'b0));
    apply(8000, 29400, 1'b0, 1'b1, 1'b1);
    check("R7", expect_word(8000, 29400, 1'b0, 1'b1, 1'b1));
  endtask

  task automatic t_hold();
    logic [15:0] held;
    apply(20000, 3000, 1'b1, 1'b1, 1'b1);
    held = expect_word(20000, 3000, 1'b1, 1'b1, 1'b1);
    check("R2", held);
    @(negedge clk);
    rx_freq = 16'd1000; tx_freq = 16'd40000;
    rx_port_rx2 = 1'b0; tx_active = 1'b0; full_duplex = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", held);
    apply(1000, 40000, 1'b0, 1'b0, 1'b0);
    check("R2", expect_word(1000, 40000, 1'b0, 1'b0, 1'b0));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rx_sweep(1'b0);
    t_rx_sweep(1'b1);
    t_tx_sweep();
    t_tx_off();
    t_duplex();
    t_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule